// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a block-wide memory port. Each request's word address is split into three fields: a word-in-block offset at the bottom, a set index above it and a tag in the remaining upper bits. The indexed set's two frames are compared against the tag at the same time. A load hit returns its word combinationally in the cycle the request is accepted.

Each set keeps one bit that names its most recently used way. On a miss the other way is replaced. Stores are write-back and write-allocate. A store is accepted in a tag-check cycle, and its word is written into the matching frame in the following cycle. That write marks the frame dirty.

On a miss the CPU port is held off. If the victim frame is dirty, the block first writes it back to memory and then fetches the missing block. The request is then looked up again and completes from the filled frame. A store miss therefore merges its word into the freshly fetched block.

Top module: `wb_cache2w`

## Requirements
- R1: The word address splits as offset = bits [OFF_W-1:0], index = the next IDX_W bits, tag = the remaining upper bits. A request hits when either way of the indexed set is valid and holds its tag. Two different tags mapping to one set can both be resident and both hit.
- R2: A load hit asserts cpuReady in the cycle the request is presented, with the addressed word on cpuRdata and no memory transaction.
- R3: Every accepted hit makes the hit way the set's most recently used way, and every fill makes the filled way the most recently used. A miss replaces the way that is not the most recently used.
- R4: A store is accepted after its tag check, and its word is written in the next cycle. A request that reaches the same set in that write cycle is stalled for one cycle, with cpuReady low, and then sees the stored word. A request to another set is not stalled.
- R5: A miss whose victim is clean or invalid makes exactly one memory transaction: a read (memWe=0) of the missing block, at block address addr[ADDR_W-1:OFF_W]. memReq and memWe hold steady until memReady.
- R6: A miss whose victim is dirty makes two transactions: first a write (memWe=1) of the victim's whole block to the victim's block address, then the fill read.
- R7: A store miss fetches the block and then writes the store word into it. The other words of the block keep their memory values.
- R8: After reset every frame is invalid and clean, all MRU bits are zero, and memReq is low.
- R9: While a miss is being serviced, cpuReady stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | CPU request valid, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | WORD_W | Store data |
| cpuReady | output | 1 | Request accepted this cycle |
| cpuRdata | output | WORD_W | Load data, valid with cpuReady on a load |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = writeback, 0 = fill read |
| memAddr | output | ADDR_W-OFF_W | Block address |
| memWdata | output | WORDS*WORD_W | Writeback block |
| memReady | input | 1 | Memory completes the transaction this cycle |
| memRdata | input | WORDS*WORD_W | Fill block, valid with memReady |

## Verification
Two functions can fall in the same cycle: the second-stage word write of an accepted store, and the tag lookup of the next request. The bench provokes the overlap by presenting a load directly behind a store, with no idle cycle, once to the same word and once to a different set. In the same-set case the load must see exactly one stall cycle and then return the stored word. In the different-set case the load must complete at once with its own data. The dirty eviction that follows is judged by the order of the memory transactions and by the written-back words found in the bench memory.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  typedef struct packed {
    logic mruTouch;
    logic stageLoad;
    logic missCapture;
    logic fillWrite;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} ctrlState_t;
endpackage

// File: rtl/wbc_dp.sv
`timescale 1ns/1ps
module wbc_dp
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_W   = WORDS * WORD_W,
  localparam int BADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [WORD_W-1:0]  cpuWdata,
  output logic [WORD_W-1:0]  cpuRdata,
  output logic               hit,
  output logic               conflict,
  output logic               victimDirty,
  output logic [BADDR_W-1:0] wbAddr,
  output logic [BADDR_W-1:0] fillAddr,
  output logic [BLK_W-1:0]   wbData,
  input  logic [BLK_W-1:0]   memRdata
);
  logic [TAG_W-1:0] tagMem  [SETS][2];
  logic [BLK_W-1:0] dataMem [SETS][2];
  logic [1:0]       validBit [SETS];
  logic [1:0]       dirtyBit [SETS];
  logic [SETS-1:0]  mruBit;

  logic [OFF_W-1:0] word;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign word = cpuAddr[OFF_W-1:0];
  assign idx  = cpuAddr[OFF_W +: IDX_W];
  assign tag  = cpuAddr[ADDR_W-1 -: TAG_W];

  logic [1:0] wayHit;
  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign wayHit[w] = validBit[idx][w] && (tagMem[idx][w] == tag);
  end

  logic hitWay, victim;
  logic [BLK_W-1:0] hitBlk;
  assign hit         = |wayHit;
  assign hitWay      = wayHit[1];
  assign victim      = ~mruBit[idx];
  assign victimDirty = validBit[idx][victim] && dirtyBit[idx][victim];
  assign hitBlk      = dataMem[idx][hitWay];
  assign cpuRdata    = hitBlk[WORD_W*int'(word) +: WORD_W];

  // store stage and miss registers
  logic             stValid, stWay;
  logic [IDX_W-1:0] stIdx;
  logic [OFF_W-1:0] stWord;
  logic [WORD_W-1:0] stData;
  logic [IDX_W-1:0] missIdx;
  logic [TAG_W-1:0] missTag, missVicTag;
  logic             missWay;

  assign conflict = stValid && (stIdx == idx);
  assign wbAddr   = {missVicTag, missIdx};
  assign fillAddr = {missTag, missIdx};
  assign wbData   = dataMem[missIdx][missWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validBit[s] <= '0;
        dirtyBit[s] <= '0;
        for (int w = 0; w < 2; w++) begin
          tagMem[s][w]  <= '0;
          dataMem[s][w] <= '0;
        end
      end
      mruBit     <= '0;
      stValid    <= 1'b0;
      stWay      <= 1'b0;
      stIdx      <= '0;
      stWord     <= '0;
      stData     <= '0;
      missIdx    <= '0;
      missTag    <= '0;
      missVicTag <= '0;
      missWay    <= 1'b0;
    end else begin
      stValid <= strobes.stageLoad;
      if (strobes.stageLoad) begin
        stIdx  <= idx;
        stWay  <= hitWay;
        stWord <= word;
        stData <= cpuWdata;
      end
      if (stValid) begin
        dataMem[stIdx][stWay][WORD_W*int'(stWord) +: WORD_W] <= stData;
        dirtyBit[stIdx][stWay] <= 1'b1;
      end
      if (strobes.mruTouch) mruBit[idx] <= hitWay;
      if (strobes.missCapture) begin
        missIdx    <= idx;
        missTag    <= tag;
        missWay    <= victim;
        missVicTag <= tagMem[idx][victim];
      end
      if (strobes.fillWrite) begin
        dataMem[missIdx][missWay]  <= memRdata;
        tagMem[missIdx][missWay]   <= missTag;
        validBit[missIdx][missWay] <= 1'b1;
        dirtyBit[missIdx][missWay] <= 1'b0;
        mruBit[missIdx]            <= missWay;
      end
    end
  end

  p_onehot_hit_r1: assert property (@(posedge clk) disable iff (!rstN) $onehot0(wayHit));
  p_no_store_fill_clash_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stValid && strobes.fillWrite));
  p_store_needs_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stageLoad |-> hit);
endmodule

// File: rtl/wbc_ctrl.sv
`timescale 1ns/1ps
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic         hit,
  input  logic         conflict,
  input  logic         victimDirty,
  input  logic         memReady,
  output ctrlStrobes_t strobes,
  output logic         cpuReady,
  output logic         memReq,
  output logic         memWe
);
  ctrlState_t state, nextState;

  always_comb begin
    strobes   = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (cpuReq && !conflict) begin
        if (hit) begin
          cpuReady          = 1'b1;
          strobes.mruTouch  = 1'b1;
          strobes.stageLoad = cpuWe;
        end else begin
          strobes.missCapture = 1'b1;
          nextState = victimDirty ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) nextState = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memReady) begin
          strobes.fillWrite = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  p_ready_held_r9: assert property (@(posedge clk) disable iff (!rstN) memReq |-> !cpuReady);
  p_mem_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe)));
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && memWe) |=> (memReq && !memWe));
endmodule

// File: rtl/wb_cache2w.sv
`timescale 1ns/1ps
module wb_cache2w
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int BLK_W = WORDS * WORD_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [WORD_W-1:0]       cpuWdata,
  output logic                    cpuReady,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-OFF_W-1:0] memAddr,
  output logic [BLK_W-1:0]        memWdata,
  input  logic                    memReady,
  input  logic [BLK_W-1:0]        memRdata
);
  ctrlStrobes_t strobes;
  logic hit, conflict, victimDirty;
  logic [ADDR_W-OFF_W-1:0] wbAddr, fillAddr;

  wbc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .conflict(conflict), .victimDirty(victimDirty), .memReady(memReady),
    .strobes(strobes), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe)
  );

  wbc_dp #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .hit(hit), .conflict(conflict), .victimDirty(victimDirty),
    .wbAddr(wbAddr), .fillAddr(fillAddr), .wbData(memWdata), .memRdata(memRdata)
  );

  assign memAddr = memWe ? wbAddr : fillAddr;

  p_mem_addr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr));
endmodule

// File: tb/wb_cache2w_test.sv
`timescale 1ns/1ps
module wb_cache2w_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic cpuReady;
  logic [31:0] cpuRdata;
  logic memReq, memWe;
  logic [9:0] memAddr;
  logic [127:0] memWdata;
  logic memReady = 1'b0;
  logic [127:0] memRdata = '0;

  always #10 clk = ~clk;

  wb_cache2w uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata)
  );

  int checks = 0, errors = 0;
  int fills = 0, wbs = 0, txnSeq = 0, lastWbSeq = 0, lastFillSeq = 0;
  logic [9:0] lastWbAddr = '0, lastFillAddr = '0;
  logic [127:0] bmem [1024];

  function automatic logic [31:0] memWord(input logic [11:0] a);
    logic [127:0] b;
    b = bmem[a[11:2]];
    return b[32*int'(a[1:0]) +: 32];
  endfunction

  // memory responder: completes each transaction after two waiting cycles
  initial begin
    int waitCnt = 0;
    for (int b = 0; b < 1024; b++)
      for (int w = 0; w < 4; w++) bmem[b][32*w +: 32] = 32'hA000_0000 | (b*4 + w);
    forever begin
      @(negedge clk);
      if (memReady) begin
        memReady = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        waitCnt++;
        if (waitCnt == 2) begin
          txnSeq++;
          if (memWe) begin
            bmem[memAddr] = memWdata;
            wbs++; lastWbAddr = memAddr; lastWbSeq = txnSeq;
          end else begin
            memRdata = bmem[memAddr];
            fills++; lastFillAddr = memAddr; lastFillSeq = txnSeq;
          end
          memReady = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d; waits = 0;
    #1;
    while (!cpuReady && waits < 500) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  // store immediately followed by a load, no idle cycle between them
  task automatic storeThenLoad(input logic [11:0] sa, input logic [31:0] sd,
                               input logic [11:0] la, output logic [31:0] rd,
                               output int waits);
    int sw = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = sa; cpuWdata = sd;
    #1;
    while (!cpuReady && sw < 500) begin @(negedge clk); #1; sw++; end
    @(posedge clk); #1;
    cpuWe = 1'b0; cpuAddr = la; waits = 0;
    @(negedge clk); #1;
    while (!cpuReady && waits < 500) begin @(negedge clk); #1; waits++; end
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0;
  endtask

  logic [31:0] rd;
  int waits, f0, w0;

  task automatic t_reset();
    chk("R8 memReq low after reset", {31'd0, memReq}, 32'd0);
    f0 = fills; w0 = wbs;
    access(1'b0, 12'h010, '0, rd, waits);
    chk("R8 first access misses", fills - f0, 1);
    chk("R5 no writeback on empty frame", wbs - w0, 0);
    chk("R9 ready held low during miss", {31'd0, waits > 2}, 32'd1);
    chk("R5 fill data", rd, 32'hA000_0010);
  endtask

  task automatic t_load_hit();
    f0 = fills;
    access(1'b0, 12'h015, '0, rd, waits);
    chk("R5 clean miss one fill", fills - f0, 1);
    chk("R5 fill block address", {22'd0, lastFillAddr}, 32'h005);
    chk("R5 miss data", rd, 32'hA000_0015);
    f0 = fills;
    access(1'b0, 12'h016, '0, rd, waits);
    chk("R2 hit same cycle", waits, 0);
    chk("R2 hit data", rd, 32'hA000_0016);
    chk("R2 hit no memory traffic", fills - f0, 0);
  endtask

  task automatic t_nmru();
    access(1'b0, 12'h025, '0, rd, waits);
    access(1'b0, 12'h026, '0, rd, waits);
    chk("R1 second tag resident", {31'd0, waits == 0}, 32'd1);
    access(1'b0, 12'h017, '0, rd, waits);
    chk("R1 first tag still resident", {31'd0, waits == 0}, 32'd1);
    chk("R1 data of first tag", rd, 32'hA000_0017);
    f0 = fills;
    access(1'b0, 12'h035, '0, rd, waits);
    chk("R3 third tag fetched", fills - f0, 1);
    chk("R3 fill address", {22'd0, lastFillAddr}, 32'h00D);
    access(1'b0, 12'h014, '0, rd, waits);
    chk("R3 MRU way kept", waits, 0);
    f0 = fills;
    access(1'b0, 12'h024, '0, rd, waits);
    chk("R3 non-MRU way evicted", fills - f0, 1);
    chk("R3 refetched data", rd, 32'hA000_0024);
  endtask

  task automatic t_write_alloc();
    f0 = fills; w0 = wbs;
    access(1'b1, 12'h042, 32'hDEAD_BEEF, rd, waits);
    chk("R7 store miss fills", fills - f0, 1);
    chk("R7 no writeback", wbs - w0, 0);
    access(1'b0, 12'h042, '0, rd, waits);
    chk("R7 merged word", rd, 32'hDEAD_BEEF);
    access(1'b0, 12'h041, '0, rd, waits);
    chk("R7 neighbour word kept", rd, 32'hA000_0041);
  endtask

  task automatic t_store_overlap();
    storeThenLoad(12'h043, 32'hCAFE_F00D, 12'h043, rd, waits);
    chk("R4 same-set stall one cycle", waits, 1);
    chk("R4 load sees stored word", rd, 32'hCAFE_F00D);
    storeThenLoad(12'h040, 32'h1111_2222, 12'h014, rd, waits);
    chk("R4 other set no stall", waits, 0);
    chk("R4 other set data", rd, 32'hA000_0014);
  endtask

  task automatic t_dirty_evict();
    f0 = fills; w0 = wbs;
    access(1'b0, 12'h050, '0, rd, waits);
    chk("R5 clean victim one transaction", (fills - f0) + (wbs - w0), 1);
    f0 = fills; w0 = wbs;
    access(1'b0, 12'h060, '0, rd, waits);
    chk("R6 dirty victim writeback", wbs - w0, 1);
    chk("R6 dirty victim fill", fills - f0, 1);
    chk("R6 writeback address", {22'd0, lastWbAddr}, 32'h010);
    chk("R6 writeback before fill", lastFillSeq - lastWbSeq, 1);
    chk("R6 written word 2", memWord(12'h042), 32'hDEAD_BEEF);
    chk("R6 written word 3", memWord(12'h043), 32'hCAFE_F00D);
    chk("R6 written word 0", memWord(12'h040), 32'h1111_2222);
    chk("R6 untouched word 1", memWord(12'h041), 32'hA000_0041);
    chk("R6 new block data", rd, 32'hA000_0060);
    access(1'b0, 12'h042, '0, rd, waits);
    chk("R6 refetch after writeback", rd, 32'hDEAD_BEEF);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_load_hit();
    t_nmru();
    t_write_alloc();
    t_store_overlap();
    t_dirty_evict();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule